// File: doc/BRIEF.md
# Bob and Weave Video Deinterlacer

This block turns a stream of interlaced luma fields into progressive frames. Each field holds every other line of a frame, and fields arrive one after another, each offset in time from the one before. The block rebuilds the lines a field lacks with one of four methods. Weave takes the co-located line from the field before. Bob takes the rounded mean of the field lines above and below. Replication copies a neighbouring field line. Dynamic mode decides per pixel between weave and bob with a motion test, so static areas keep full detail and moving edges do not feather.

Pixels enter on a valid/ready stream with start-of-field, start-of-line and field-parity markers. The block writes a whole field into one of two field banks. It then emits the full-height frame in raster order on a valid/ready output stream. The other bank holds the previous field, which weave and the motion test read. The mode, the motion threshold and the parity are captured with the start-of-field beat. They stay fixed until the next one.

Top module: `deinterlacer`

## Requirements
- R1: After reset, out_valid_o is 0, in_ready_o is 1, and both field banks read as zero, so the first weave frame has zero in every rebuilt line.
- R2: A field with parity 0 (top) provides output lines 0, 2, 4, …, and a field with parity 1 (bottom) provides lines 1, 3, 5, …. Field line k appears unchanged as output line 2k+parity.
- R3: Weave (mode 0) fills rebuilt output line y with line y/2 (rounded down) of the previous field.
- R4: Bob (mode 1) fills a rebuilt line with (above+below+1)/2 of the current field lines next to it. At the top or bottom edge of the frame it uses the single neighbour that exists.
- R5: Replication (mode 2) fills a rebuilt line with the current field line directly above it. On output line 0 it uses the line below.
- R6: Dynamic (mode 3) outputs the bob value for a pixel when |previous-field pixel − bob value| is greater than the threshold, and the weave value otherwise.
- R7: Each frame is 2×FIELD_H lines of LINE_W pixels in raster order. out_sof_o is 1 only on the first pixel of a frame and out_sol_o on the first pixel of each line.
- R8: While out_valid_o is 1 and out_ready_i is 0, the output pixel and markers hold steady and no pixel is lost. in_ready_o is 0 for as long as out_valid_o is 1.
- R9: mode_i, thresh_i and in_parity_i are sampled only on an accepted beat with in_sof_i=1. Changes on other beats have no effect on the frame.
- R10: Beats accepted while no field is open (before any start-of-field) are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input pixel valid |
| in_ready_o | output | 1 | Block accepts an input pixel |
| in_data_i | input | DATA_W | Input luma sample |
| in_sof_i | input | 1 | First pixel of a field |
| in_sol_i | input | 1 | First pixel of a field line; restarts the column on the next line |
| in_parity_i | input | 1 | Field parity with the start-of-field beat: 0 top, 1 bottom |
| mode_i | input | 2 | 0 weave, 1 bob, 2 replicate, 3 dynamic |
| thresh_i | input | DATA_W | Motion threshold for dynamic mode |
| out_valid_o | output | 1 | Output pixel valid |
| out_ready_i | input | 1 | Downstream accepts the output pixel |
| out_data_o | output | DATA_W | Output luma sample |
| out_sof_o | output | 1 | First pixel of a progressive frame |
| out_sol_o | output | 1 | First pixel of an output line |

## Verification
The fields fed in are random, all-maximum and ramp patterns. They run in every mode with both parities, so pass-through lines, edge neighbours and bob rounding at full scale are each exposed. Dynamic mode runs with a zero, a maximum and random thresholds, which separates the bob branch from the weave branch per pixel. Before each field, discarded junk beats are sent, and mode, threshold and parity toggle on non-start beats. Random input gaps and output stalls show whether a pixel is dropped or changes while held.

// File: rtl/dil_pkg.sv
package dil_pkg;
  typedef enum logic [1:0] {
    MODE_WEAVE = 2'd0,
    MODE_BOB   = 2'd1,
    MODE_REPL  = 2'd2,
    MODE_DYN   = 2'd3
  } dil_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_EMIT = 2'd2
  } dil_state_e;
endpackage

// File: rtl/dil_field_store.sv
module dil_field_store #(
  parameter int DATA_W  = 8,
  parameter int LINE_W  = 8,
  parameter int FIELD_H = 4,
  localparam int XW = $clog2(LINE_W),
  localparam int FW = $clog2(FIELD_H)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              wbank_i,
  input  logic [FW-1:0]     wline_i,
  input  logic [XW-1:0]     wcol_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rbank_i,
  input  logic [XW-1:0]     rcol_i,
  input  logic [FW-1:0]     up_line_i,
  input  logic [FW-1:0]     dn_line_i,
  input  logic [FW-1:0]     prev_line_i,
  output logic [DATA_W-1:0] up_o,
  output logic [DATA_W-1:0] dn_o,
  output logic [DATA_W-1:0] prev_o
);
  logic [DATA_W-1:0] mem_q [2][FIELD_H][LINE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < 2; b++)
        for (int l = 0; l < FIELD_H; l++)
          for (int c = 0; c < LINE_W; c++)
            mem_q[b][l][c] <= '0;
    end else if (we_i) begin
      mem_q[wbank_i][wline_i][wcol_i] <= wdata_i;
    end
  end

  // current field from rbank, previous field from the other bank
  assign up_o   = mem_q[rbank_i][up_line_i][rcol_i];
  assign dn_o   = mem_q[rbank_i][dn_line_i][rcol_i];
  assign prev_o = mem_q[~rbank_i][prev_line_i][rcol_i];
endmodule

// File: rtl/dil_pixel_calc.sv
module dil_pixel_calc
  import dil_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  dil_mode_e         mode_i,
  input  logic [DATA_W-1:0] thresh_i,
  input  logic              field_line_i,
  input  logic              has_up_i,
  input  logic              has_dn_i,
  input  logic [DATA_W-1:0] up_i,
  input  logic [DATA_W-1:0] dn_i,
  input  logic [DATA_W-1:0] prev_i,
  output logic [DATA_W-1:0] pix_o
);
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] bob, rep, diff;
  logic              motion;

  always_comb begin
    sum = {1'b0, up_i} + {1'b0, dn_i} + {{DATA_W{1'b0}}, 1'b1};
    if (has_up_i && has_dn_i) bob = sum[DATA_W:1];
    else if (has_up_i)        bob = up_i;
    else                      bob = dn_i;
    rep    = has_up_i ? up_i : dn_i;
    diff   = (prev_i > bob) ? (prev_i - bob) : (bob - prev_i);
    motion = diff > thresh_i;
    if (field_line_i) pix_o = up_i;
    else begin
      unique case (mode_i)
        MODE_WEAVE: pix_o = prev_i;
        MODE_BOB:   pix_o = bob;
        MODE_REPL:  pix_o = rep;
        default:    pix_o = motion ? bob : prev_i;
      endcase
    end
  end
endmodule

// File: rtl/deinterlacer.sv
module deinterlacer
  import dil_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int LINE_W  = 8,
  parameter int FIELD_H = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_sof_i,
  input  logic              in_sol_i,
  input  logic              in_parity_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] thresh_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_sof_o,
  output logic              out_sol_o
);
  localparam int XW = $clog2(LINE_W);
  localparam int FW = $clog2(FIELD_H);
  localparam int YW = FW + 1;
  localparam logic [XW-1:0] LAST_COL = XW'(LINE_W - 1);
  localparam logic [FW-1:0] LAST_ROW = FW'(FIELD_H - 1);
  localparam logic [YW-1:0] LAST_Y   = YW'(2 * FIELD_H - 1);

  dil_state_e        state_q;
  dil_mode_e         mode_q;
  logic [DATA_W-1:0] thr_q;
  logic              par_q, bank_q;
  logic [XW-1:0]     col_q, ox_q, wcol;
  logic [FW-1:0]     row_q, wrow;
  logic [YW-1:0]     oy_q, y_up, y_dn;
  logic              acc, wr_en, w_last;
  logic              field_line, has_up, has_dn;
  logic [FW-1:0]     up_line, dn_line;
  logic [DATA_W-1:0] rd_up, rd_dn, rd_prev;

  assign in_ready_o  = (state_q != ST_EMIT);
  assign out_valid_o = (state_q == ST_EMIT);
  assign acc         = in_valid_i && in_ready_o;
  assign wr_en       = acc && (in_sof_i || state_q == ST_FILL);

  // write position; a line marker mid-line moves to the next line
  always_comb begin
    if (in_sof_i) begin
      wrow = '0;
      wcol = '0;
    end else if (in_sol_i && col_q != '0 && row_q != LAST_ROW) begin
      wrow = row_q + 1'b1;
      wcol = '0;
    end else begin
      wrow = row_q;
      wcol = col_q;
    end
    w_last = (wrow == LAST_ROW) && (wcol == LAST_COL);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_WEAVE;
      thr_q   <= '0;
      par_q   <= 1'b0;
      bank_q  <= 1'b0;
      col_q   <= '0;
      row_q   <= '0;
      ox_q    <= '0;
      oy_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE, ST_FILL: begin
          if (wr_en) begin
            if (in_sof_i) begin
              mode_q <= dil_mode_e'(mode_i);
              thr_q  <= thresh_i;
              par_q  <= in_parity_i;
            end
            if (w_last) begin
              state_q <= ST_EMIT;
              ox_q    <= '0;
              oy_q    <= '0;
            end else begin
              state_q <= ST_FILL;
              col_q   <= (wcol == LAST_COL) ? '0 : wcol + 1'b1;
              row_q   <= (wcol == LAST_COL) ? wrow + 1'b1 : wrow;
            end
          end
        end
        ST_EMIT: begin
          if (out_ready_i) begin
            if (ox_q == LAST_COL) begin
              ox_q <= '0;
              if (oy_q == LAST_Y) begin
                state_q <= ST_IDLE;
                bank_q  <= ~bank_q;
              end else begin
                oy_q <= oy_q + 1'b1;
              end
            end else begin
              ox_q <= ox_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // neighbour lines of output line oy_q, as field line indices
  always_comb begin
    y_up       = oy_q - 1'b1;
    y_dn       = oy_q + 1'b1;
    field_line = (oy_q[0] == par_q);
    has_up     = (oy_q != '0);
    has_dn     = (oy_q != LAST_Y);
    up_line    = field_line ? oy_q[YW-1:1] : y_up[YW-1:1];
    dn_line    = y_dn[YW-1:1];
  end

  dil_field_store #(
    .DATA_W (DATA_W),
    .LINE_W (LINE_W),
    .FIELD_H(FIELD_H)
  ) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_en),
    .wbank_i    (bank_q),
    .wline_i    (wrow),
    .wcol_i     (wcol),
    .wdata_i    (in_data_i),
    .rbank_i    (bank_q),
    .rcol_i     (ox_q),
    .up_line_i  (up_line),
    .dn_line_i  (dn_line),
    .prev_line_i(oy_q[YW-1:1]),
    .up_o       (rd_up),
    .dn_o       (rd_dn),
    .prev_o     (rd_prev)
  );

  dil_pixel_calc #(.DATA_W(DATA_W)) u_calc (
    .mode_i      (mode_q),
    .thresh_i    (thr_q),
    .field_line_i(field_line),
    .has_up_i    (has_up),
    .has_dn_i    (has_dn),
    .up_i        (rd_up),
    .dn_i        (rd_dn),
    .prev_i      (rd_prev),
    .pix_o       (out_data_o)
  );

  assign out_sof_o = (ox_q == '0) && (oy_q == '0);
  assign out_sol_o = (ox_q == '0);

  AST_NO_INPUT_IN_EMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o); // R8
  AST_STALL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o)
      && $stable(out_sof_o) && $stable(out_sol_o)); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_IDLE) && !(acc && in_sof_i) |=> $stable(mode_q) && $stable(thr_q)
      && $stable(par_q)); // R9
  AST_SOF_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_sof_o |=> !out_sof_o); // R7
  AST_FIELD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && field_line |-> out_data_o == rd_up); // R2
  AST_BOB_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && mode_q == MODE_BOB && !field_line && has_up && has_dn |->
      (out_data_o >= ((rd_up < rd_dn) ? rd_up : rd_dn)) &&
      (out_data_o <= ((rd_up < rd_dn) ? rd_dn : rd_up))); // R4
endmodule

// File: tb/tb_deinterlacer.sv
`timescale 1ns/1ps
module tb_deinterlacer;
  localparam int DW = 8;
  localparam int W  = 8;
  localparam int H  = 4;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0, in_par = 1'b0;
  logic [DW-1:0] in_data = '0, thresh = '0;
  logic [1:0]    mode = '0;
  logic          out_ready = 1'b0;
  logic          in_ready, out_valid, out_sof, out_sol;
  logic [DW-1:0] out_data;

  int total = 0, bad = 0;
  logic [DW-1:0] cur  [H][W];
  logic [DW-1:0] prev [H][W];
  int f_par, f_mode, f_thr;

  always #2.5 clk = ~clk;

  deinterlacer #(.DATA_W(DW), .LINE_W(W), .FIELD_H(H)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data),
    .in_sof_i(in_sof), .in_sol_i(in_sol), .in_parity_i(in_par),
    .mode_i(mode), .thresh_i(thresh),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data),
    .out_sof_o(out_sof), .out_sol_o(out_sol)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_pix(int y, int x);
    int a, b, bob, rep, pv, d;
    bit hu, hd;
    if ((y % 2) == f_par) return int'(cur[y/2][x]);
    hu  = (y > 0);
    hd  = (y < 2*H-1);
    a   = hu ? int'(cur[(y-1)/2][x]) : 0;
    b   = hd ? int'(cur[(y+1)/2][x]) : 0;
    bob = (hu && hd) ? (a + b + 1) / 2 : (hu ? a : b);
    rep = hu ? a : b;
    pv  = int'(prev[y/2][x]);
    case (f_mode)
      0: return pv;
      1: return bob;
      2: return rep;
      default: begin
        d = (pv > bob) ? pv - bob : bob - pv;
        return (d > f_thr) ? bob : pv;
      end
    endcase
  endfunction

  function automatic string req_of(int y);
    if ((y % 2) == f_par) return "R2";
    case (f_mode)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // pattern 0 random, 1 all max, 2 ramp
  task automatic run_field(input int par, input int md, input int thr, input int pat);
    int idx, cnt, junk, held;
    bit stalled;
    f_par = par; f_mode = md; f_thr = thr;
    for (int l = 0; l < H; l++)
      for (int c = 0; c < W; c++)
        cur[l][c] = (pat == 1) ? 8'hff : (pat == 2) ? DW'(l*40 + c*9) : DW'($urandom);
    // R10: junk beats with no field open are discarded
    junk = $urandom_range(0, 3);
    idx = 0;
    while (idx < junk) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_sol = 1'b0;
      in_data = DW'($urandom); mode = 2'($urandom);
      if (in_ready) idx++;
    end
    idx = 0;
    while (idx < H*W) begin
      @(negedge clk);
      out_ready = 1'($urandom);
      if (($urandom % 4) == 0) begin
        in_valid = 1'b0;
        mode = 2'($urandom); thresh = DW'($urandom);
      end else begin
        in_valid = 1'b1;
        in_data  = cur[idx/W][idx%W];
        in_sof   = (idx == 0);
        in_sol   = (idx % W == 0);
        if (idx == 0) begin
          in_par = 1'(par); mode = 2'(md); thresh = DW'(thr);
        end else begin
          // R9: configuration noise away from the start-of-field beat
          in_par = 1'($urandom); mode = 2'($urandom); thresh = DW'($urandom);
        end
        if (in_ready) idx++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0;
    cnt = 0; stalled = 1'b0; held = 0;
    while (cnt < 2*H*W) begin
      if (stalled) check(out_valid && int'(out_data) == held, "R8 hold", int'(out_data), held);
      check(!(out_valid && in_ready), "R8 ready", int'(in_ready), 0);
      out_ready = ($urandom % 3) != 0;
      if (out_valid && out_ready) begin
        check(int'(out_data) == exp_pix(cnt / W, cnt % W), req_of(cnt / W),
              int'(out_data), exp_pix(cnt / W, cnt % W));
        check(out_sof == (cnt == 0) && out_sol == (cnt % W == 0), "R7",
              int'({out_sof, out_sol}), int'({cnt == 0, cnt % W == 0}));
        cnt++;
        stalled = 1'b0;
      end else begin
        stalled = out_valid;
        held = int'(out_data);
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R8 end", int'(out_valid), 0);
    for (int l = 0; l < H; l++)
      for (int c = 0; c < W; c++)
        prev[l][c] = cur[l][c];
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0d17));
    for (int l = 0; l < H; l++)
      for (int c = 0; c < W; c++)
        prev[l][c] = '0;
    repeat (3) @(negedge clk);
    check(!out_valid && in_ready, "R1", int'({out_valid, in_ready}), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1", int'({out_valid, in_ready}), 1);
    run_field(0, 0, 0, 0);    // R1: weave against zeroed bank
    run_field(1, 0, 0, 2);    // R3
    run_field(0, 1, 0, 1);    // R4 full-scale rounding
    run_field(1, 1, 0, 0);    // R4 edges
    run_field(0, 2, 0, 0);    // R5
    run_field(1, 2, 0, 2);    // R5 top edge
    run_field(0, 3, 255, 0);  // R6 always weave
    run_field(1, 3, 0, 0);    // R6 mostly bob
    run_field(0, 3, 20, 2);
    for (int i = 0; i < 12; i++)
      run_field(int'($urandom % 2), int'($urandom % 4), int'($urandom % 64), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule